// File: doc/BRIEF.md
# Programmable Down-Counter/Timer with Receive Timeout

This block is a down-counter built for a dual UART. Its width is set by a parameter and is 16 bits by default. A CPU controls it through a small byte-wide register bus: writes, reads and an address. A single-cycle enable from the selected counter clock source advances the count. The CPU starts and stops the counter by reading two command addresses, so the block takes no write data for either command.

A two-bit mode input selects one of three behaviours:

- **Counter mode.** The count falls to zero and raises a ready flag. It then wraps to all-ones and keeps counting down until the CPU stops it.
- **Timer mode.** The counter reloads at each terminal count and toggles a square-wave output, which can serve as a baud-rate clock source and as a periodic interrupt. A stop command cannot halt it in this mode.
- **Receive-timeout mode.** The counter reloads each time the receiver moves a character into its FIFO. It raises the ready flag only if the count reaches zero before the next character arrives.

Top module: `ctr_timer`

## Requirements
- R1: After reset, the count reads 0x0000, and the ready flag, the interrupt output and the square-wave output are all low.
- R2: A read at address 0xE is the start command. The next tick loads the preload value into the count, where the preload value is written as an upper byte at address 0x6 and a lower byte at address 0x7. Each later tick decrements the count by one, and the count never changes on a cycle without a tick or a receive strobe.
- R3: In counter mode (mode 00), a decrement that lands on 0x0000 sets the ready flag. The ready flag is output `rdy` and is also bit 3 of the byte read at address 0x5. The next tick gives 0xFFFF, and counting continues from there.
- R4: The interrupt output is high exactly while the ready flag is set and mask bit 3, written at address 0x5, is set.
- R5: A preload write made while the counter runs leaves the running count unchanged. The next start command loads the new value.
- R6: In counter mode and receive-timeout mode, a read at address 0xF is the stop command. It halts the count, and in every mode it clears the ready flag.
- R7: Reads at address 0x6 return the upper byte of the current count and reads at 0x7 return the lower byte. Reads at any other address except 0x5 return 0.
- R8: In timer mode (mode 01), the square-wave output toggles and the count reloads after every run of preload ticks, and each toggle sets the ready flag. One full period therefore lasts twice the preload in ticks.
- R9: In timer mode the stop command clears the ready flag but does not halt the counter.
- R10: In receive-timeout mode (mode 10), a receive strobe loads the preload value into the count at once, and the following ticks count down from it. Reaching 0x0000 before the next strobe sets the ready flag. Outside timer mode the square-wave output holds its level.
- R11: A preload value of 0 counts as 65536, so zero is reached on the 65536th tick after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| mode | input | 2 | Mode: 00 counter, 01 timer, 10 receive timeout |
| tick | input | 1 | One-cycle enable from the counter clock source |
| rx_push | input | 1 | A received character entered the receive FIFO |
| rd_en | input | 1 | Register read strobe |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational during rd_en |
| rdy | output | 1 | Counter-ready flag |
| irq | output | 1 | Interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
The bench uses the default 16-bit count, 4-bit address and 8-bit data widths. At these widths the wrap from 0x0000 to 0xFFFF is observed through both count bytes. The full-width width also brings the zero-preload case within reach: the bench runs all 65536 ticks and checks that the ready flag stays low on the tick before the last one. Ticks arrive on every cycle, which keeps the square-wave half-periods short enough to check edge by edge.

// File: rtl/ctr_timer.sv
module ctr_timer #(
  parameter int CW = 16,
  parameter int AW = 4,
  parameter int DW = 8,
  parameter logic [AW-1:0] A_STAT  = 4'h5,
  parameter logic [AW-1:0] A_HI    = 4'h6,
  parameter logic [AW-1:0] A_LO    = 4'h7,
  parameter logic [AW-1:0] A_START = 4'hE,
  parameter logic [AW-1:0] A_STOP  = 4'hF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    mode,
  input  logic          tick,
  input  logic          rx_push,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rdy,
  output logic          irq,
  output logic          sqw
);
  localparam int HW = CW - DW;
  localparam int RB = 3;
  localparam logic [1:0] M_TMR = 2'b01;
  localparam logic [1:0] M_RXT = 2'b10;

  logic [CW-1:0] cnt;
  logic [HW-1:0] pre_hi;
  logic [DW-1:0] pre_lo;
  logic          run, pend, msk;

  wire [CW-1:0] pre = {pre_hi, pre_lo};
  wire tmr     = (mode == M_TMR);
  wire start   = rd_en && (addr == A_START);
  wire stop    = rd_en && (addr == A_STOP);
  wire rx_load = rx_push && (mode == M_RXT);
  wire halt    = stop && !tmr;
  wire busy    = rx_load || start || halt;
  wire ld      = tick && run && pend && !busy;
  wire adv     = tick && run && !pend && !busy;
  wire tc      = adv && (cnt == CW'(1));

  logic unused_wbits;
  assign unused_wbits = ^{wdata[DW-1:RB+1], wdata[RB-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      pre_hi <= '0;
      pre_lo <= '0;
      run    <= 1'b0;
      pend   <= 1'b0;
      msk    <= 1'b0;
      rdy    <= 1'b0;
      sqw    <= 1'b0;
    end else begin
      if (wr_en && addr == A_HI)   pre_hi <= wdata[HW-1:0];
      if (wr_en && addr == A_LO)   pre_lo <= wdata;
      if (wr_en && addr == A_STAT) msk    <= wdata[RB];

      if (rx_load) begin
        cnt  <= pre;
        run  <= 1'b1;
        pend <= 1'b0;
      end else if (start) begin
        run  <= 1'b1;
        pend <= 1'b1;
      end else if (halt) begin
        run  <= 1'b0;
        pend <= 1'b0;
      end else if (ld) begin
        cnt  <= pre;
        pend <= 1'b0;
      end else if (adv) begin
        if (tmr && tc) cnt <= pre;
        else           cnt <= cnt - CW'(1);
      end

      if (stop)    rdy <= 1'b0;
      else if (tc) rdy <= 1'b1;

      if (tc && tmr) sqw <= ~sqw;
    end
  end

  assign irq = rdy && msk;

  always_comb begin
    rdata = '0;
    if (rd_en) begin
      if (addr == A_STAT) rdata[RB] = rdy;
      if (addr == A_HI)   rdata[HW-1:0] = cnt[CW-1:DW];
      if (addr == A_LO)   rdata = cnt[DW-1:0];
    end
  end
endmodule

module ctr_timer_chk #(
  parameter int CW = 16,
  parameter int AW = 4,
  parameter logic [AW-1:0] A_STOP = 4'hF
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    mode,
  input logic          tick,
  input logic          rx_push,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [CW-1:0] cnt,
  input logic          run,
  input logic          pend,
  input logic          rdy,
  input logic          irq,
  input logic          sqw
);
  // R2
  hold_no_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !rx_push) |=> $stable(cnt));

  // R3
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run && !pend && mode == 2'b00 && !rx_push && !rd_en) |=> cnt == $past(cnt) - CW'(1));

  // R6
  stop_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == A_STOP) |=> !rdy);

  // R9
  tmr_nohalt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b01 && run && rd_en && addr == A_STOP && !rx_push) |=> run);

  // R8
  sqw_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick || mode != 2'b01) |=> $stable(sqw));

  // R4
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> rdy);
endmodule

bind ctr_timer ctr_timer_chk #(.CW(CW), .AW(AW), .A_STOP(A_STOP)) u_chk (
  .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .rx_push(rx_push),
  .rd_en(rd_en), .addr(addr), .cnt(cnt), .run(run), .pend(pend),
  .rdy(rdy), .irq(irq), .sqw(sqw)
);

// File: tb/ctr_timer_tb.sv
module ctr_timer_tb;
  localparam time CYC = 8ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       tick = 1'b0, rx_push = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       rdy, irq, sqw;

  int n_run = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #(CYC/2) clk = ~clk;

  ctr_timer u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tick(tick), .rx_push(rx_push),
    .rd_en(rd_en), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .rdy(rdy), .irq(irq), .sqw(sqw)
  );

  always @(negedge clk) begin
    if (rst_n && rd_en) begin
      n_run++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL scoreboard empty: actual %02h expected none", rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: read actual %02h expected %02h", t, rdata, e);
        end
      end
    end
  end

  task automatic chk(string t, logic [15:0] act, logic [15:0] e);
    n_run++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", t, act, e);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [7:0] e, string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    step();
    rd_en = 1'b0;
  endtask

  task automatic rdcnt(logic [15:0] e, string t);
    rd(4'h6, e[15:8], t);
    rd(4'h7, e[7:0], t);
  endtask

  task automatic ticks(int n);
    tick = 1'b1;
    repeat (n) step();
    tick = 1'b0;
  endtask

  task automatic rx();
    rx_push = 1'b1;
    step();
    rx_push = 1'b0;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    #(CYC * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1
    rdcnt(16'h0000, "R1 count");
    chk("R1 rdy", rdy, 0); chk("R1 irq", irq, 0); chk("R1 sqw", sqw, 0);

    // R2 / R3 / R4
    wr(4'h6, 8'h00); wr(4'h7, 8'h05); wr(4'h5, 8'h08);
    rd(4'hE, 8'h00, "R7 start reads 0");
    ticks(1);
    rdcnt(16'h0005, "R2 load");
    ticks(4);
    rdcnt(16'h0001, "R2 decrement");
    chk("R3 rdy before zero", rdy, 0);
    ticks(1);
    chk("R3 rdy at zero", rdy, 1);
    chk("R4 irq unmasked", irq, 1);
    rd(4'h5, 8'h08, "R3 status bit 3");
    ticks(1);
    rdcnt(16'hFFFF, "R3 wrap");

    // R5
    wr(4'h7, 8'h09);
    ticks(1);
    rdcnt(16'hFFFE, "R5 running count unchanged");

    // R6
    rd(4'hF, 8'h00, "R7 stop reads 0");
    chk("R6 rdy cleared", rdy, 0);
    chk("R4 irq cleared", irq, 0);
    ticks(3);
    rdcnt(16'hFFFE, "R6 halted");

    rd(4'hE, 8'h00, "R7 start reads 0");
    ticks(1);
    rdcnt(16'h0009, "R5 new preload on start");
    wr(4'h5, 8'h00);
    ticks(9);
    chk("R4 rdy masked", rdy, 1);
    chk("R4 irq masked", irq, 0);
    rd(4'h3, 8'h00, "R7 other address");
    rd(4'hF, 8'h00, "R6 stop");

    // R8 / R9
    mode = 2'b01;
    wr(4'h7, 8'h03);
    rd(4'hE, 8'h00, "R8 start");
    ticks(1);
    chk("R8 sqw low after load", sqw, 0);
    ticks(2);
    chk("R8 sqw low before tc", sqw, 0);
    ticks(1);
    chk("R8 sqw first toggle", sqw, 1);
    chk("R8 rdy on toggle", rdy, 1);
    ticks(2);
    chk("R8 sqw held", sqw, 1);
    ticks(1);
    chk("R8 sqw second toggle", sqw, 0);
    rd(4'hF, 8'h00, "R9 stop");
    chk("R9 rdy cleared", rdy, 0);
    ticks(3);
    chk("R9 still running sqw", sqw, 1);
    chk("R9 rdy set again", rdy, 1);

    // R10
    mode = 2'b10;
    rd(4'hF, 8'h00, "R10 stop");
    wr(4'h7, 8'h04);
    rx();
    rdcnt(16'h0004, "R10 strobe load");
    ticks(3);
    chk("R10 rdy before zero", rdy, 0);
    rx();
    ticks(3);
    rdcnt(16'h0001, "R10 reloaded");
    chk("R10 no timeout", rdy, 0);
    ticks(1);
    chk("R10 timeout", rdy, 1);
    chk("R10 sqw held", sqw, 1);
    rdcnt(16'h0000, "R10 count zero");

    // R11
    mode = 2'b00;
    rd(4'hF, 8'h00, "R11 stop");
    wr(4'h7, 8'h00);
    rd(4'hE, 8'h00, "R11 start");
    ticks(1);
    rdcnt(16'h0000, "R11 load zero");
    chk("R11 rdy after load", rdy, 0);
    ticks(65535);
    rdcnt(16'h0001, "R11 near end");
    chk("R11 rdy not yet", rdy, 0);
    ticks(1);
    chk("R11 rdy after 65536", rdy, 1);

    step();
    finish_run();
  end
endmodule